// File: doc/BRIEF.md
# Interleaved ADC sample recovery

This block sits between an already deserialized, lane-aligned receive bus and a waveform storage interface in one converter channel. The channel uses two sub-converters, I and Q. Each samples the same analog input at half the aggregate rate, and Q runs on the inverse clock phase of I, so their samples alternate in time. Each converter bit travels on its own serial lane, and the deserializer hands over four bits per lane in every receive-clock cycle.

In every cycle that carries a valid word, the block takes the 64-bit word from the sixteen lanes. It regroups the lane bits into eight 8-bit samples in strict time order: even output slots take I samples and odd slots take Q samples. It presents the eight samples one register stage later with a valid strobe. A synchronous reset clears the strobe.

Top module: `adc_ilv_recover`

## Requirements
- R1: `outValid` is high in the cycle after a cycle in which `inValid` was high, and low in the cycle after a cycle in which `inValid` was low. The latency is exactly one register stage.
- R2: After a synchronous reset, `outValid` is 0 and `outSamples` is all zeros.
- R3: Each output sample k occupies `outSamples[8k+7:8k]`, with k=0 the oldest sample. Even k is taken from the I lanes, which are lanes 0 to 7.
- R4: Odd k is taken from the Q lanes, which are lanes 8 to 15.
- R5: Lane j occupies `inWord[4j+3:4j]`, and its four bits are in time order with bit 3 the oldest. Sample k uses lane bit 3-(k/2), where k/2 is integer division.
- R6: Lane j carries bit (j mod 8) of its sub-converter's sample, so `outSamples[8k+b]` = `inWord[4*(8*(k mod 2)+b) + 3-(k/2)]`.
- R7: While `inValid` is low, `outSamples` keeps its previous value.
- R8: A reset that arrives while valid words are streaming drives `outValid` low in the next cycle, whatever the value of `inValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks the current input word as valid |
| inWord | input | 64 | Deserialized word, four bits per lane |
| outValid | output | 1 | Marks the current output samples as valid |
| outSamples | output | 64 | Eight samples in time order, oldest in the low byte |

## Verification
The hardest case is telling a correct bit permutation apart from one that is almost right. A swapped time index or a swapped I/Q slot still gives plausible sample values on most random words. To expose such swaps, the stimulus includes directed words that set a single lane bit. Each of those words lights exactly one output bit, so every one of the 64 source positions is mapped without ambiguity. Random words with random gaps in `inValid` then cover the hold behaviour and the reset that lands in the middle of a stream.

// File: rtl/adc_ilv_pkg.sv
package adc_ilv_pkg;
  localparam int SAMPLE_W   = 8;
  localparam int SUB_CNT    = 2;
  localparam int LANE_CNT   = SAMPLE_W * SUB_CNT;
  localparam int LANE_BITS  = 4;
  localparam int WORD_W     = LANE_CNT * LANE_BITS;
  localparam int SAMPLE_CNT = WORD_W / SAMPLE_W;

  typedef struct packed {
    logic load;
    logic clear;
  } ilvStrobe_t;
endpackage

// File: rtl/adc_ilv_ctrl.sv
module adc_ilv_ctrl
  import adc_ilv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output ilvStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/adc_ilv_datapath.sv
module adc_ilv_datapath
  import adc_ilv_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  parameter int LB = LANE_BITS,
  parameter int SC = SUB_CNT,
  localparam int LC = SW * SC,
  localparam int WW = LC * LB,
  localparam int NS = WW / SW
) (
  input  logic          clk,
  input  ilvStrobe_t    strobe,
  input  logic [WW-1:0] inWord,
  output logic [WW-1:0] outSamples
);
  logic [WW-1:0] remapped;

  for (genvar k = 0; k < NS; k++) begin : g_sample
    localparam int SUB = k % SC;
    localparam int TIX = k / SC;
    for (genvar b = 0; b < SW; b++) begin : g_bit
      localparam int LANE = SUB * SW + b;
      assign remapped[k*SW + b] = inWord[LANE*LB + (LB-1-TIX)];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)     outSamples <= '0;
    else if (strobe.load) outSamples <= remapped;
  end
endmodule

// File: rtl/adc_ilv_recover.sv
module adc_ilv_recover
  import adc_ilv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  output logic [WORD_W-1:0] outSamples
);
  ilvStrobe_t strobe;

  adc_ilv_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  adc_ilv_datapath #(.SW(SAMPLE_W), .LB(LANE_BITS), .SC(SUB_CNT)) dp_i (
    .clk(clk), .strobe(strobe), .inWord(inWord), .outSamples(outSamples)
  );
endmodule

// File: rtl/adc_ilv_recover_chk.sv
module adc_ilv_recover_chk
  import adc_ilv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [WORD_W-1:0] inWord,
  input logic              outValid,
  input logic [WORD_W-1:0] outSamples
);
  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (!outValid && outSamples == '0));
  p_oldest_i_r3: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outSamples[0] == $past(inWord[LANE_BITS-1]));
  p_oldest_q_r4: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outSamples[SAMPLE_W] == $past(inWord[SAMPLE_W*LANE_BITS + LANE_BITS-1]));
  p_newest_q_msb_r5: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outSamples[WORD_W-1] == $past(inWord[(LANE_CNT-1)*LANE_BITS]));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outSamples));
endmodule

bind adc_ilv_recover adc_ilv_recover_chk chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
  .outValid(outValid), .outSamples(outSamples)
);

// File: tb/adc_ilv_recover_tb_top.sv
module adc_ilv_recover_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [WW-1:0] inWord = '0;
  logic outValid;
  logic [WW-1:0] outSamples;

  int checks = 0;
  int failures = 0;
  logic [WW-1:0] lastExp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ilv_recover dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outSamples(outSamples)
  );

  function automatic logic [WW-1:0] expMap(input logic [WW-1:0] w);
    logic [WW-1:0] r;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 8; b++)
        r[8*k + b] = w[4*(8*(k % 2) + b) + 3 - (k / 2)];
    return r;
  endfunction

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sample 1 time unit after the next posedge
  task automatic step(input logic v, input logic [WW-1:0] w, input logic r);
    @(negedge clk);
    inValid = v; inWord = w; rst = r;
    @(posedge clk); #1;
  endtask

  task automatic push(input logic v, input logic [WW-1:0] w, input string req);
    step(v, w, 1'b0);
    check({req, " valid"}, {63'b0, outValid}, {63'b0, v});
    if (v) lastExp = expMap(w);
    check({req, " data"}, outSamples, lastExp);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b1);
    check("R2 reset valid", {63'b0, outValid}, 64'd0);
    check("R2 reset data", outSamples, '0);

    // directed single-bit words map every source bit
    for (int i = 0; i < WW; i++) begin
      logic [WW-1:0] w;
      int lane, tb, sub, bit_i, k;
      w = '0; w[i] = 1'b1;
      lane = i / 4; tb = i % 4; sub = lane / 8; bit_i = lane % 8;
      k = 2 * (3 - tb) + sub;
      push(1'b1, w, sub == 0 ? "R3 R5 R6 I lane bit" : "R4 R5 R6 Q lane bit");
      check("R6 single position", outSamples, 64'd1 << (8*k + bit_i));
    end

    // hold while idle
    push(1'b1, 64'h0123_4567_89ab_cdef, "R3 R4 pattern");
    push(1'b0, 64'hffff_ffff_ffff_ffff, "R7 hold idle");
    push(1'b0, 64'h0, "R7 hold idle2");
    push(1'b1, 64'hf0f0_f0f0_0f0f_0f0f, "R5 time order");
    push(1'b1, 64'h00000000_ffffffff, "R3 I only");
    push(1'b1, 64'hffffffff_00000000, "R4 Q only");

    // random traffic with gaps
    for (int n = 0; n < 300; n++) begin
      logic [WW-1:0] w;
      w = {$urandom, $urandom};
      push(($urandom % 4) != 0, w, "R1 R6 random");
    end

    // reset in the middle of a stream
    push(1'b1, 64'hdead_beef_cafe_f00d, "R1 stream");
    step(1'b1, 64'h1111_2222_3333_4444, 1'b1);
    check("R8 reset mid-stream valid", {63'b0, outValid}, 64'd0);
    check("R8 reset mid-stream data", outSamples, '0);
    lastExp = '0;
    push(1'b1, 64'h8000_0000_0000_0001, "R1 after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule